// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire management bus that connects a MAC-side controller to external PHY devices. Software programs a target address, then writes a single command word whose start bit launches a transaction. The block builds each serial frame, produces the management clock from its own clock with a selectable divider, shifts the frame out on the data pin, and releases the pin to capture the PHY's reply on reads. A busy bit in the command word stays set for the whole transaction and clears when the transaction ends.

Both extended-address frames (a separate address frame followed by a data frame) and short direct-register frames are produced from the same command word. A skip bit suppresses the extended address frame. An opcode reads with a post-increment of the stored register address. A one-hot port mask limits short-form access to four ports. The data pin is modelled as three signals: output value, output enable and input.

The register port is plain control: a write strobe with an offset and a combinational read. There is no back-pressure on it. Writes that arrive while a transaction is running are dropped, and software is expected to poll the busy bit.

Top module: `mdio_master`

## Requirements
- R1: Offsets: 0 = target address (32 bits, reads back as written), 1 = command word, 2 = port mask (bits [3:0]). The command word reads as data [15:0], opcode [17:16], skip [18], divider [21:19], busy [22], and zero above. Offset 3 reads zero. Everything resets to zero.
- R2: Writing offset 1 with bit 22 set while idle starts a transaction. Bit 22 then reads 1 until the transaction ends, and reads 0 afterwards.
- R3: The management clock is low while idle. During a frame, each of its phases lasts 2<<divider clock cycles.
- R4: Every frame is 64 bits, most significant first: 32 ones, start [2], opcode [2], port [5], device or register [5], turnaround [2], data [16]. Address bit 30 = 1 selects the extended form. Here, without skip, an address frame is sent first (start 00, opcode 00, port = address [20:16], device = address [25:21], turnaround 10, data = address [15:0]). A data frame follows, carrying the command opcode (01 write, 10 read with increment, 11 read).
- R5: With skip set, an extended transaction sends only the data frame.
- R6: A short-form frame uses start 01, opcode 01 for write and 10 for either read opcode, and register = address [4:0].
- R7: A short-form transaction runs only if the port is below 4 and its port-mask bit is set. The same applies to opcode 00 in either form. Otherwise no frame is sent and busy clears within 3 cycles of the write.
- R8: On reads the pin is released (enable 0) from the turnaround through the data bits. The input is sampled when the management clock rises, MSB first, and the result appears in command bits [15:0].
- R9: An extended read with increment adds 1 (mod 2^16) to address bits [15:0] at completion and leaves the other address bits unchanged. The short form never increments.
- R10: Writes to offsets 0, 1 and 2 while busy have no effect.
- R11: The output data bit changes only while the management clock is low. It never changes in a cycle where the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input |

## Verification
Extended writes and reads are tried with and without the skip bit, and with three divider settings. Comparing these separates the two-frame sequence from the single-frame one and ties the measured clock period to the divider field. Short-form writes and reads on permitted ports are set against refused ones: a high port number, a cleared mask bit, and the empty opcode. These show that the mask and port limit gate the bus and that nothing leaks onto it. An increment read at address 0xFFFF checks wrap-around and that the upper fields are kept, and a short-form increment read checks that no increment happens. Writes landed mid-transaction confirm that the registers do not move.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN = 32;
  localparam int FRAME_W = PRE_LEN + 32;
  localparam int DIV_W   = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WR    = 2'b01,
    OP_RDINC = 2'b10,
    OP_RD    = 2'b11
  } mdio_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_ADDR, S_DATA, S_FIN
  } seq_e;

  function automatic logic [FRAME_W-1:0] mk_frame(
    input logic [1:0]  st,
    input logic [1:0]  op,
    input logic [4:0]  pa,
    input logic [4:0]  ra,
    input logic [1:0]  ta,
    input logic [15:0] dat);
    return {{PRE_LEN{1'b1}}, st, op, pa, ra, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(2) << sel;
  assign tick = run && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int FW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame,
  input  logic          rd,
  input  logic          tick,
  input  logic          mdi,
  output logic          active,
  output logic          done,
  output logic          mdc,
  output logic          mdo,
  output logic          oe,
  output logic [15:0]   rdata
);
  localparam int IW      = $clog2(FW);
  localparam int TA_IDX  = FW - 18;
  localparam int DAT_IDX = FW - 16;

  logic [IW-1:0] idx;
  logic [FW-1:0] sh;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      mdc    <= 1'b0;
      rd_q   <= 1'b0;
      idx    <= '0;
      sh     <= '0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        rd_q   <= rd;
        idx    <= '0;
        sh     <= frame;
        mdc    <= 1'b0;
        rdata  <= '0;
      end else if (active && tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && idx >= IW'(DAT_IDX)) rdata <= {rdata[14:0], mdi};
        end else begin
          mdc <= 1'b0;
          if (idx == IW'(FW - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx <= idx + IW'(1);
            sh  <= {sh[FW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdo = sh[FW-1];
  assign oe  = active && !(rd_q && idx >= IW'(TA_IDX));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0]      addr_q;
  logic [15:0]      data_q;
  mdio_op_e         op_q;
  logic             skip_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_q;
  logic [3:0]       psel_q;
  seq_e             state;

  logic               wr_ok, tick, eng_active, eng_done;
  logic               eng_start, eng_rd;
  logic [FRAME_W-1:0] eng_frame, addr_frame, data_frame;
  logic [15:0]        eng_rdata;
  logic               c45, c22_ok, legal, read_op, st_fin;
  logic [4:0]         pa;
  logic [1:0]         ta;

  assign wr_ok   = reg_wr && !busy_q;
  assign c45     = addr_q[30];
  assign pa      = addr_q[20:16];
  assign c22_ok  = (pa < 5'd4) && psel_q[pa[1:0]];
  assign read_op = op_q[1];
  assign legal   = (op_q != OP_NONE) && (c45 || c22_ok);
  assign ta      = read_op ? 2'b11 : 2'b10;
  assign st_fin  = (state == S_FIN);

  assign addr_frame = mk_frame(2'b00, 2'b00, pa, addr_q[25:21], 2'b10, addr_q[15:0]);

  always_comb begin
    if (c45)
      data_frame = mk_frame(2'b00, op_q, pa, addr_q[25:21], ta,
                            read_op ? 16'hFFFF : data_q);
    else
      data_frame = mk_frame(2'b01, read_op ? 2'b10 : 2'b01, pa, addr_q[4:0], ta,
                            read_op ? 16'hFFFF : data_q);
  end

  always_comb begin
    eng_start = 1'b0;
    eng_rd    = 1'b0;
    eng_frame = data_frame;
    if (state == S_LAUNCH && legal) begin
      eng_start = 1'b1;
      if (c45 && !skip_q) eng_frame = addr_frame;
      else                eng_rd    = read_op;
    end else if (state == S_ADDR && eng_done) begin
      eng_start = 1'b1;
      eng_rd    = read_op;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      op_q   <= OP_NONE;
      skip_q <= 1'b0;
      div_q  <= '0;
      busy_q <= 1'b0;
      psel_q <= '0;
      state  <= S_IDLE;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          2'd0: addr_q <= reg_wdata;
          2'd1: begin
            data_q <= reg_wdata[15:0];
            op_q   <= mdio_op_e'(reg_wdata[17:16]);
            skip_q <= reg_wdata[18];
            div_q  <= reg_wdata[21:19];
            busy_q <= reg_wdata[22];
            if (reg_wdata[22]) state <= S_LAUNCH;
          end
          2'd2: psel_q <= reg_wdata[3:0];
          default: ;
        endcase
      end
      case (state)
        S_LAUNCH: begin
          if (!legal)                state <= S_FIN;
          else if (c45 && !skip_q)   state <= S_ADDR;
          else                       state <= S_DATA;
        end
        S_ADDR: if (eng_done) state <= S_DATA;
        S_DATA: if (eng_done) state <= S_FIN;
        S_FIN: begin
          busy_q <= 1'b0;
          state  <= S_IDLE;
          if (legal && read_op) data_q <= eng_rdata;
          if (legal && c45 && op_q == OP_RDINC)
            addr_q[15:0] <= addr_q[15:0] + 16'd1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = addr_q;
      2'd1:    reg_rdata = {9'd0, busy_q, div_q, skip_q, op_q, data_q};
      2'd2:    reg_rdata = {28'd0, psel_q};
      default: reg_rdata = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_active),
    .sel  (div_q),
    .tick (tick)
  );

  mdio_frame_eng #(.FW(FRAME_W)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .frame (eng_frame),
    .rd    (eng_rd),
    .tick  (tick),
    .mdi   (mdio_i),
    .active(eng_active),
    .done  (eng_done),
    .mdc   (mdc_o),
    .mdo   (mdio_o),
    .oe    (mdio_oe),
    .rdata (eng_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        fin,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] addr_q,
  input logic        mdc,
  input logic        mdo,
  input logic        oe
);
  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_pin_released_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !oe);

  assert_addr_held_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && reg_wr && reg_addr == 2'd0) |=> $stable(addr_q));

  assert_mdo_steady_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdo));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_q),
  .fin     (st_fin),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr),
  .addr_q  (addr_q),
  .mdc     (mdc_o),
  .mdo     (mdio_o),
  .oe      (mdio_oe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdo, oe, mdi;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  logic [63:0] cap = '0;
  logic [15:0] phy_rd = 16'h0000;
  int bcnt = 0;
  int frames = 0;
  time last_rise = 0;
  int last_per = 0;
  int mdo_bad = 0;
  logic prev_mdo = 1'b0;

  always #5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe(oe), .mdio_i(mdi)
  );

  // PHY model: presents its reply bits from the data phase on
  assign mdi = (bcnt >= 48) ? phy_rd[4'(63 - bcnt)] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
    input logic [4:0] pa, input logic [4:0] ra, input logic [1:0] ta,
    input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, ta, d};
  endfunction

  // monitor / scoreboard
  always @(posedge mdc) begin
    cap = {cap[62:0], oe ? mdo : mdi};
    if (last_rise != 0) last_per = int'(($time - last_rise) / 10);
    last_rise = $time;
    bcnt++;
    if (bcnt == 64) begin
      bcnt = 0;
      frames++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected frame", cap, '0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(cap == e, "R4 frame content", cap, e);
      end
    end
  end

  // R11: output bit never moves while clock is high
  always @(negedge clk) begin
    if (mdc && mdo !== prev_mdo) mdo_bad++;
    prev_mdo = mdo;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rdr(2'd1, v);
      if (!v[22]) break;
    end
  endtask

  function automatic logic [31:0] cmdw(input logic [1:0] op, input bit skip,
    input logic [2:0] dv, input logic [15:0] d);
    return (32'd1 << 22) | (32'(dv) << 19) | (32'(skip) << 18) | (32'(op) << 16) | 32'(d);
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rdr(2'(i), v);
      chk(v == 0, "R1 reset value", v, 0);
    end
    chk(!mdc && !oe, "R3 idle pins", {mdc, oe}, 0);

    // R1 readback
    wr(2'd2, 32'hFFFF_FFF6);
    rdr(2'd2, v); chk(v == 32'h6, "R1 port mask readback", v, 32'h6);
    wr(2'd0, 32'h8123_4567);
    rdr(2'd0, v); chk(v == 32'h8123_4567, "R1 address readback", v, 32'h8123_4567);

    // R4 extended write with address frame, divider 1
    a = (32'd1 << 30) | (32'd7 << 21) | (32'd9 << 16) | 32'h1234;
    wr(2'd0, a);
    exp_q.push_back(fr(2'b00, 2'b00, 5'd9, 5'd7, 2'b10, 16'h1234));
    exp_q.push_back(fr(2'b00, 2'b01, 5'd9, 5'd7, 2'b10, 16'hBEEF));
    wr(2'd1, cmdw(2'b01, 0, 3'd1, 16'hBEEF));
    rdr(2'd1, v); chk(v[22] == 1'b1, "R2 busy set", v, 32'h0040_0000);
    wait_idle();
    rdr(2'd1, v); chk(v[22] == 1'b0, "R2 busy clear", v, 0);
    chk(last_per == 8, "R3 period div1", last_per, 8);
    chk(exp_q.size() == 0 && frames == 2, "R4 two frames", frames, 2);

    // R5/R8 extended read with skip, divider 0
    phy_rd = 16'hA5C3;
    exp_q.push_back(fr(2'b00, 2'b11, 5'd9, 5'd7, 2'b11, 16'hA5C3));
    wr(2'd1, cmdw(2'b11, 1, 3'd0, 16'h0000));
    wait_idle();
    chk(frames == 3, "R5 single frame", frames, 3);
    rdr(2'd1, v); chk(v[15:0] == 16'hA5C3, "R8 read data", v[15:0], 16'hA5C3);
    chk(last_per == 4, "R3 period div0", last_per, 4);

    // R9 increment read with wrap, divider 2
    a = (32'd1 << 30) | (32'd3 << 21) | (32'd1 << 16) | 32'hFFFF;
    wr(2'd0, a);
    phy_rd = 16'h0F0F;
    exp_q.push_back(fr(2'b00, 2'b00, 5'd1, 5'd3, 2'b10, 16'hFFFF));
    exp_q.push_back(fr(2'b00, 2'b10, 5'd1, 5'd3, 2'b11, 16'h0F0F));
    wr(2'd1, cmdw(2'b10, 0, 3'd2, 16'h0000));
    wait_idle();
    rdr(2'd0, v); chk(v == (a & 32'hFFFF_0000), "R9 increment wrap", v, a & 32'hFFFF_0000);
    rdr(2'd1, v); chk(v[15:0] == 16'h0F0F, "R8 read data inc", v[15:0], 16'h0F0F);
    chk(last_per == 16, "R3 period div2", last_per, 16);

    // R6 short-form write on port 2 (mask 0110)
    a = (32'd2 << 16) | 32'h0ABC;
    wr(2'd0, a);
    exp_q.push_back(fr(2'b01, 2'b01, 5'd2, 5'h1C, 2'b10, 16'h5A5A));
    wr(2'd1, cmdw(2'b01, 0, 3'd0, 16'h5A5A));
    wait_idle();
    chk(frames == 6, "R6 short write frame", frames, 6);

    // R6/R9 short-form increment read on port 1: opcode 10, no increment
    a = (32'd1 << 16) | 32'h0013;
    wr(2'd0, a);
    phy_rd = 16'h1357;
    exp_q.push_back(fr(2'b01, 2'b10, 5'd1, 5'h13, 2'b11, 16'h1357));
    wr(2'd1, cmdw(2'b10, 0, 3'd0, 16'h0000));
    wait_idle();
    rdr(2'd0, v); chk(v == a, "R9 no short increment", v, a);
    rdr(2'd1, v); chk(v[15:0] == 16'h1357, "R8 short read data", v[15:0], 16'h1357);

    // R7 refused: port 5, then port 3 not in mask, then empty opcode
    f0 = frames;
    wr(2'd0, 32'd5 << 16);
    wr(2'd1, cmdw(2'b01, 0, 3'd0, 16'h0));
    repeat (2) @(negedge clk);
    rdr(2'd1, v); chk(v[22] == 1'b0, "R7 port5 busy clears", v, 0);
    wr(2'd0, 32'd3 << 16);
    wr(2'd1, cmdw(2'b11, 0, 3'd0, 16'h0));
    repeat (2) @(negedge clk);
    rdr(2'd1, v); chk(v[22] == 1'b0, "R7 unmasked busy clears", v, 0);
    wr(2'd0, (32'd1 << 30) | (32'd1 << 16));
    wr(2'd1, cmdw(2'b00, 0, 3'd0, 16'h0));
    repeat (2) @(negedge clk);
    rdr(2'd1, v); chk(v[22] == 1'b0, "R7 empty opcode busy clears", v, 0);
    repeat (300) @(negedge clk);
    chk(frames == f0, "R7 no frame sent", frames, f0);

    // R10 writes while busy ignored
    a = (32'd1 << 30) | (32'd2 << 21) | (32'd4 << 16) | 32'h0042;
    wr(2'd0, a);
    exp_q.push_back(fr(2'b00, 2'b01, 5'd4, 5'd2, 2'b10, 16'h7777));
    wr(2'd1, cmdw(2'b01, 1, 3'd0, 16'h7777));
    wr(2'd0, 32'h0000_1111);
    rdr(2'd0, v); chk(v == a, "R10 address held", v, a);
    wr(2'd1, 32'h0000_2222);
    rdr(2'd1, v); chk(v[15:0] == 16'h7777 && v[22], "R10 command held", v, 32'h7777);
    wr(2'd2, 32'h0);
    rdr(2'd2, v); chk(v == 32'h6, "R10 mask held", v, 32'h6);
    wait_idle();
    rdr(2'd0, v); chk(v == a, "R10 address after", v, a);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    chk(mdo_bad == 0, "R11 output steady while clock high", mdo_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule